// File: doc/BRIEF.md
# Pipelined MD5 Candidate Matcher

This block hashes short candidate strings with MD5 and flags the ones whose digest equals a stored target. One candidate of up to eight characters can enter on every clock. The block pads it into a single 512-bit message block and pushes it through 64 registered stages, one per MD5 step. At the end it adds the initial chaining values and compares the 128-bit digest with the target.

The message block, the candidate and its length travel with the A/B/C/D state. A hit is therefore reported in the same cycle as the string that produced it. A valid bit moves with each slot, so idle cycles form bubbles that can never match. The target is written through a separate load port before a search starts. A search manager feeds candidates at full rate and watches for the hit flag.

Top module: `md5w_match_worker`

## Requirements
- R1: While reset is high and in the cycle after it, hit_o is 0. hit_cand_o and hit_len_o are 0 until the first hit.
- R2: A new candidate is accepted on every rising edge where in_valid_i is 1, with no stall. Its result appears on hit_o after the 66th rising edge, counting the edge that captured it.
- R3: Character k of the candidate is in_cand_i[8k+7:8k]. The message is the first L characters, where L is in_len_i, and a length above 8 is treated as 8. The block is padded in the usual MD5 way: byte 0x80 follows the message, then zero bytes, then the bit count (8·L) as a little-endian 64-bit value in the last 8 bytes.
- R4: The digest is compared with tgt as a 128-bit value whose bits [127:120] hold the first digest byte. This matches the usual hex spelling, so the empty string gives d41d8cd98f00b204e9800998ecf8427e.
- R5: hit_o is 1 only for a slot that entered with in_valid_i high. Bubbles never hit, whatever is on in_cand_i.
- R6: On a hit, hit_cand_o shows the candidate exactly as it was supplied and hit_len_o shows its effective length. Both hold their values until the next hit.
- R7: A pulse on tgt_load_i stores tgt_i. Every compare made after that edge uses the new target.
- R8: A candidate whose digest differs from the target gives no hit. Bytes of in_cand_i at positions L and above do not change the digest.
- R9: Candidates sent back to back are hashed independently. Several consecutive hits show up on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Candidate present this cycle |
| in_cand_i | input | CAND_W (64) | Candidate characters, first character in the low byte |
| in_len_i | input | LEN_W (4) | Candidate length in characters |
| tgt_load_i | input | 1 | Write tgt_i into the target register |
| tgt_i | input | 128 | Target digest, first byte in the top bits |
| hit_o | output | 1 | Digest of the emerging slot equals the target |
| hit_cand_o | output | CAND_W (64) | Candidate of the most recent hit |
| hit_len_o | output | LEN_W (4) | Effective length of the most recent hit |

## Verification
The bench builds the block with its default of eight characters, which gives a 64-bit candidate port and a 4-bit length port. This width lets lengths above eight be driven, so the clamp can be checked. It also lets junk bytes sit past the end of a short string, which checks that they are ignored. The full 66-stage pipeline is in place, so long streams of back-to-back candidates mixed with bubbles can be compared, slot by slot, against a bench-side MD5 model. Two well-known digests anchor the byte order of the target.

// File: rtl/md5w_pkg.sv
`timescale 1ns/1ps
package md5w_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 16;
  localparam int unsigned STEPS     = 64;
  localparam int unsigned DIG_W     = 4 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [BLK_WORDS-1:0] blk_t;
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } abcd_t;

  localparam word_t IV_A = 32'h67452301;
  localparam word_t IV_B = 32'hefcdab89;
  localparam word_t IV_C = 32'h98badcfe;
  localparam word_t IV_D = 32'h10325476;

  // additive constant for each step
  function automatic word_t step_const(input int unsigned i);
    case (i)
      0:  return 32'hd76aa478;  1:  return 32'he8c7b756;
      2:  return 32'h242070db;  3:  return 32'hc1bdceee;
      4:  return 32'hf57c0faf;  5:  return 32'h4787c62a;
      6:  return 32'ha8304613;  7:  return 32'hfd469501;
      8:  return 32'h698098d8;  9:  return 32'h8b44f7af;
      10: return 32'hffff5bb1;  11: return 32'h895cd7be;
      12: return 32'h6b901122;  13: return 32'hfd987193;
      14: return 32'ha679438e;  15: return 32'h49b40821;
      16: return 32'hf61e2562;  17: return 32'hc040b340;
      18: return 32'h265e5a51;  19: return 32'he9b6c7aa;
      20: return 32'hd62f105d;  21: return 32'h02441453;
      22: return 32'hd8a1e681;  23: return 32'he7d3fbc8;
      24: return 32'h21e1cde6;  25: return 32'hc33707d6;
      26: return 32'hf4d50d87;  27: return 32'h455a14ed;
      28: return 32'ha9e3e905;  29: return 32'hfcefa3f8;
      30: return 32'h676f02d9;  31: return 32'h8d2a4c8a;
      32: return 32'hfffa3942;  33: return 32'h8771f681;
      34: return 32'h6d9d6122;  35: return 32'hfde5380c;
      36: return 32'ha4beea44;  37: return 32'h4bdecfa9;
      38: return 32'hf6bb4b60;  39: return 32'hbebfbc70;
      40: return 32'h289b7ec6;  41: return 32'heaa127fa;
      42: return 32'hd4ef3085;  43: return 32'h04881d05;
      44: return 32'hd9d4d039;  45: return 32'he6db99e5;
      46: return 32'h1fa27cf8;  47: return 32'hc4ac5665;
      48: return 32'hf4292244;  49: return 32'h432aff97;
      50: return 32'hab9423a7;  51: return 32'hfc93a039;
      52: return 32'h655b59c3;  53: return 32'h8f0ccc92;
      54: return 32'hffeff47d;  55: return 32'h85845dd1;
      56: return 32'h6fa87e4f;  57: return 32'hfe2ce6e0;
      58: return 32'ha3014314;  59: return 32'h4e0811a1;
      60: return 32'hf7537e82;  61: return 32'hbd3af235;
      62: return 32'h2ad7d2bb;  default: return 32'heb86d391;
    endcase
  endfunction

  // left-rotate amount for each step
  function automatic int unsigned step_shift(input int unsigned i);
    int unsigned r;
    int unsigned p;
    r = i / 16;
    p = i % 4;
    case (r)
      0: case (p) 0: return 7;  1: return 12; 2: return 17; default: return 22; endcase
      1: case (p) 0: return 5;  1: return 9;  2: return 14; default: return 20; endcase
      2: case (p) 0: return 4;  1: return 11; 2: return 16; default: return 23; endcase
      default: case (p) 0: return 6;  1: return 10; 2: return 15; default: return 21; endcase
    endcase
  endfunction

  // message word consumed by each step
  function automatic int unsigned step_word(input int unsigned i);
    case (i / 16)
      0:       return i % 16;
      1:       return (5 * i + 1) % 16;
      2:       return (3 * i + 5) % 16;
      default: return (7 * i) % 16;
    endcase
  endfunction

  function automatic word_t mix_fn(input int unsigned rnd, input word_t x, input word_t y,
                                   input word_t z);
    case (rnd)
      0:       return (x & y) | (~x & z);
      1:       return (x & z) | (y & ~z);
      2:       return x ^ y ^ z;
      default: return y ^ (x | ~z);
    endcase
  endfunction

  function automatic word_t rotl(input word_t v, input int unsigned s);
    return (v << s) | (v >> (WORD_W - s));
  endfunction

  function automatic word_t bswap(input word_t v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/md5w_pad.sv
`timescale 1ns/1ps
module md5w_pad
  import md5w_pkg::*;
#(
  parameter int MAX_CHARS = 8,
  localparam int CAND_W = 8 * MAX_CHARS,
  localparam int LEN_W  = $clog2(MAX_CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [CAND_W-1:0] cand_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              vld_o,
  output blk_t              blk_o,
  output logic [CAND_W-1:0] cand_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int BLK_BYTES = BLK_WORDS * 4;
  localparam int LEN_BYTE0 = BLK_BYTES - 8;

  logic [LEN_W-1:0]          eff_len;
  logic [63:0]               bit_cnt;
  logic [BLK_BYTES-1:0][7:0] msg_bytes;

  always_comb begin
    eff_len = (int'(len_i) > MAX_CHARS) ? LEN_W'(MAX_CHARS) : len_i;
    bit_cnt = 64'(eff_len) << 3;
    msg_bytes = '0;
    for (int k = 0; k < MAX_CHARS; k++) begin
      if (k < int'(eff_len)) msg_bytes[k] = cand_i[8*k +: 8];
    end
    msg_bytes[eff_len] = 8'h80;
    for (int k = 0; k < 8; k++) begin
      msg_bytes[LEN_BYTE0 + k] = bit_cnt[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    blk_o  <= blk_t'(msg_bytes);
    cand_o <= cand_i;
    len_o  <= eff_len;
  end
endmodule

// File: rtl/md5w_step.sv
`timescale 1ns/1ps
module md5w_step
  import md5w_pkg::*;
#(
  parameter int STEP = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  vld_i,
  input  abcd_t st_i,
  input  word_t msg_i,
  output logic  vld_o,
  output abcd_t st_o
);
  localparam int unsigned RND = STEP / 16;
  localparam int unsigned SH  = step_shift(STEP);
  localparam word_t       KC  = step_const(STEP);

  word_t mixed;
  word_t sum;
  abcd_t nxt;

  always_comb begin
    mixed = mix_fn(RND, st_i.b, st_i.c, st_i.d);
    sum   = st_i.a + mixed + KC + msg_i;
    nxt.a = st_i.d;
    nxt.d = st_i.c;
    nxt.c = st_i.b;
    nxt.b = st_i.b + rotl(sum, SH);
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    st_o <= nxt;
  end
endmodule

// File: rtl/md5w_cmp.sv
`timescale 1ns/1ps
module md5w_cmp
  import md5w_pkg::*;
#(
  parameter int CAND_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  abcd_t             st_i,
  input  logic [CAND_W-1:0] cand_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIG_W-1:0]  tgt_i,
  output logic              hit_o,
  output logic [CAND_W-1:0] hit_cand_o,
  output logic [LEN_W-1:0]  hit_len_o
);
  logic [DIG_W-1:0] digest;
  logic             same;

  always_comb begin
    digest = {bswap(st_i.a + IV_A), bswap(st_i.b + IV_B),
              bswap(st_i.c + IV_C), bswap(st_i.d + IV_D)};
    same   = vld_i && (digest == tgt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o      <= 1'b0;
      hit_cand_o <= '0;
      hit_len_o  <= '0;
    end else begin
      hit_o <= same;
      if (same) begin
        hit_cand_o <= cand_i;
        hit_len_o  <= len_i;
      end
    end
  end
endmodule

// File: rtl/md5w_match_worker.sv
`timescale 1ns/1ps
module md5w_match_worker
  import md5w_pkg::*;
#(
  parameter int MAX_CHARS = 8,
  localparam int CAND_W = 8 * MAX_CHARS,
  localparam int LEN_W  = $clog2(MAX_CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [CAND_W-1:0] in_cand_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic              tgt_load_i,
  input  logic [127:0]      tgt_i,
  output logic              hit_o,
  output logic [CAND_W-1:0] hit_cand_o,
  output logic [LEN_W-1:0]  hit_len_o
);
  // slot index k is the input of step k; index STEPS feeds the compare
  logic              vld_q  [0:STEPS];
  abcd_t             st_q   [0:STEPS];
  blk_t              blk_q  [0:STEPS-1];
  logic [CAND_W-1:0] cand_q [0:STEPS];
  logic [LEN_W-1:0]  len_q  [0:STEPS];
  logic [DIG_W-1:0]  tgt_q;

  always_ff @(posedge clk) begin
    if (rst)             tgt_q <= '0;
    else if (tgt_load_i) tgt_q <= tgt_i;
  end

  md5w_pad #(.MAX_CHARS(MAX_CHARS)) pad_i (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (in_valid_i),
    .cand_i (in_cand_i),
    .len_i  (in_len_i),
    .vld_o  (vld_q[0]),
    .blk_o  (blk_q[0]),
    .cand_o (cand_q[0]),
    .len_o  (len_q[0])
  );

  assign st_q[0] = '{a: IV_A, b: IV_B, c: IV_C, d: IV_D};

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    md5w_step #(.STEP(k)) step_i (
      .clk   (clk),
      .rst   (rst),
      .vld_i (vld_q[k]),
      .st_i  (st_q[k]),
      .msg_i (blk_q[k][step_word(k)]),
      .vld_o (vld_q[k+1]),
      .st_o  (st_q[k+1])
    );

    always_ff @(posedge clk) begin
      cand_q[k+1] <= cand_q[k];
      len_q[k+1]  <= len_q[k];
    end

    if (k < STEPS - 1) begin : g_blk
      always_ff @(posedge clk) blk_q[k+1] <= blk_q[k];
    end
  end

  md5w_cmp #(.CAND_W(CAND_W), .LEN_W(LEN_W)) cmp_i (
    .clk        (clk),
    .rst        (rst),
    .vld_i      (vld_q[STEPS]),
    .st_i       (st_q[STEPS]),
    .cand_i     (cand_q[STEPS]),
    .len_i      (len_q[STEPS]),
    .tgt_i      (tgt_q),
    .hit_o      (hit_o),
    .hit_cand_o (hit_cand_o),
    .hit_len_o  (hit_len_o)
  );
endmodule

// File: rtl/md5w_match_worker_chk.sv
`timescale 1ns/1ps
module md5w_match_worker_chk #(
  parameter int MAX_CHARS = 8,
  parameter int CAND_W    = 64,
  parameter int LEN_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid_i,
  input logic [LEN_W-1:0]  in_len_i,
  input logic              pad_vld,
  input logic [31:0]       pad_w14,
  input logic              last_vld,
  input logic              hit_o,
  input logic [CAND_W-1:0] hit_cand_o,
  input logic              tgt_load_i,
  input logic [127:0]      tgt_i,
  input logic [127:0]      tgt_q
);
  logic rst_d;
  always @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) assert_quiet_after_reset_R1: assert (!hit_o);
  end

  assert_enter_every_edge_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> pad_vld);

  assert_pad_bitcount_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && int'(in_len_i) <= MAX_CHARS) |=> pad_w14 == 32'({$past(in_len_i), 3'b000}));

  assert_hit_needs_slot_R5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(last_vld));

  assert_cand_held_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(hit_cand_o) |-> hit_o);

  assert_target_written_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_load_i |=> tgt_q == $past(tgt_i));
endmodule

bind md5w_match_worker md5w_match_worker_chk #(
  .MAX_CHARS(MAX_CHARS), .CAND_W(CAND_W), .LEN_W(LEN_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid_i (in_valid_i),
  .in_len_i   (in_len_i),
  .pad_vld    (vld_q[0]),
  .pad_w14    (blk_q[0][14]),
  .last_vld   (vld_q[md5w_pkg::STEPS]),
  .hit_o      (hit_o),
  .hit_cand_o (hit_cand_o),
  .tgt_load_i (tgt_load_i),
  .tgt_i      (tgt_i),
  .tgt_q      (tgt_q)
);

// File: tb/md5w_match_worker_tb_top.sv
`timescale 1ns/1ps
module md5w_match_worker_tb_top;
  localparam int MAXC = 8;
  localparam int CW   = 64;
  localparam int LW   = 4;
  localparam int LAT  = 66;
  localparam int NCYC = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid_i = 1'b0;
  logic [CW-1:0] in_cand_i = '0;
  logic [LW-1:0] in_len_i = '0;
  logic          tgt_load_i = 1'b0;
  logic [127:0]  tgt_i = '0;
  logic          hit_o;
  logic [CW-1:0] hit_cand_o;
  logic [LW-1:0] hit_len_o;

  always #5 clk = ~clk;  // 100 MHz

  md5w_match_worker #(.MAX_CHARS(MAXC)) dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_cand_i(in_cand_i),
    .in_len_i(in_len_i), .tgt_load_i(tgt_load_i), .tgt_i(tgt_i),
    .hit_o(hit_o), .hit_cand_o(hit_cand_o), .hit_len_o(hit_len_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  bit            exp_hit  [NCYC];
  logic [CW-1:0] exp_cand [NCYC];
  logic [LW-1:0] exp_len  [NCYC];
  logic [CW-1:0] held_cand = '0;
  logic [LW-1:0] held_len = '0;
  logic [127:0]  cur_tgt = '0;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // independent MD5 of the first n characters (clamped to 8)
  function automatic logic [127:0] ref_md5(input logic [63:0] c, input int n_in);
    logic [7:0]  m [64];
    logic [31:0] w [16];
    logic [31:0] a, b, cc, d, f, t, k;
    logic [63:0] bits;
    int g, sh, n;
    int sh_tab[16] = '{7, 12, 17, 22, 5, 9, 14, 20, 4, 11, 16, 23, 6, 10, 15, 21};
    real s;
    n = (n_in > 8) ? 8 : n_in;
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    for (int i = 0; i < n; i++) m[i] = c[8*i +: 8];
    m[n] = 8'h80;
    bits = 64'(n) * 64'd8;
    for (int i = 0; i < 8; i++) m[56+i] = bits[8*i +: 8];
    for (int j = 0; j < 16; j++) w[j] = {m[4*j+3], m[4*j+2], m[4*j+1], m[4*j]};
    a = 32'h67452301; b = 32'hefcdab89; cc = 32'h98badcfe; d = 32'h10325476;
    for (int i = 0; i < 64; i++) begin
      case (i / 16)
        0: begin f = (b & cc) | (~b & d); g = i; end
        1: begin f = (d & b) | (~d & cc); g = (5*i + 1) % 16; end
        2: begin f = b ^ cc ^ d; g = (3*i + 5) % 16; end
        default: begin f = cc ^ (b | ~d); g = (7*i) % 16; end
      endcase
      s = $sin(real'(i + 1));
      if (s < 0.0) s = -s;
      k = 32'(longint'($floor(s * 4294967296.0)));
      sh = sh_tab[(i/16)*4 + (i%4)];
      t = a + f + k + w[g];
      a = d; d = cc; cc = b;
      b = b + ((t << sh) | (t >> (32 - sh)));
    end
    return {bsw(a + 32'h67452301), bsw(b + 32'hefcdab89),
            bsw(cc + 32'h98badcfe), bsw(d + 32'h10325476)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle; records the expected outcome LAT edges later
  task automatic drive(input bit v, input logic [63:0] c, input int n);
    int idx;
    @(negedge clk);
    in_valid_i = v; in_cand_i = c; in_len_i = LW'(n); tgt_load_i = 1'b0;
    idx = cyc + LAT;
    if (v && idx < NCYC && ref_md5(c, n) == cur_tgt) begin
      exp_hit[idx]  = 1'b1;
      exp_cand[idx] = c;
      exp_len[idx]  = LW'((n > 8) ? 8 : n);
    end
  endtask

  task automatic load_tgt(input logic [127:0] t);
    @(negedge clk);
    in_valid_i = 1'b0; tgt_load_i = 1'b1; tgt_i = t; cur_tgt = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 64'hdead_beef_0bad_f00d, 3);
  endtask

  always @(negedge clk) begin
    if (mon_en && cyc < NCYC) begin
      check(hit_o == exp_hit[cyc], "R5 R8 R9 R2 hit_o", 128'(hit_o), 128'(exp_hit[cyc]));
      if (exp_hit[cyc]) begin
        held_cand = exp_cand[cyc];
        held_len  = exp_len[cyc];
      end
      check(hit_cand_o == held_cand, "R6 hit_cand_o", 128'(hit_cand_o), 128'(held_cand));
      check(hit_len_o == held_len, "R6 R3 hit_len_o", 128'(hit_len_o), 128'(held_len));
    end
  end

  initial begin
    logic [63:0] secret;
    logic [63:0] c;
    int r, n, dummy;
    dummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    check(hit_o == 1'b0, "R1 hit_o in reset", 128'(hit_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(hit_o == 1'b0 && hit_cand_o == '0 && hit_len_o == '0, "R1 after reset",
          {hit_o, hit_cand_o, hit_len_o}, 0);
    mon_en = 1'b1;

    // known answers pin the byte order of the target (R4)
    check(ref_md5(64'h0, 0) == 128'hd41d8cd98f00b204e9800998ecf8427e, "R4 model empty",
          ref_md5(64'h0, 0), 128'hd41d8cd98f00b204e9800998ecf8427e);
    check(ref_md5(64'h0000006f6c6c6568, 5) == 128'h5d41402abc4b2a76b9719d911017c592,
          "R4 model hello", ref_md5(64'h0000006f6c6c6568, 5), 128'h5d41402abc4b2a76b9719d911017c592);

    // R4 R8: empty string with junk in every byte
    load_tgt(128'hd41d8cd98f00b204e9800998ecf8427e);
    drive(1'b1, 64'h7e7e_4142_4344_4546, 0);
    idle(LAT + 4);

    // R4 R3: hello hits, a prefix of it does not
    load_tgt(128'h5d41402abc4b2a76b9719d911017c592);
    drive(1'b1, 64'h0000006f6c6c6568, 5);
    drive(1'b1, 64'h0000006f6c6c6568, 4);
    drive(1'b1, 64'h5858586f6c6c6568, 5);
    idle(LAT + 4);

    // R3: length above 8 is clamped to 8
    load_tgt(ref_md5(64'h64726f7773736170, 8));
    drive(1'b1, 64'h64726f7773736170, 12);
    drive(1'b1, 64'h64726f7773736170, 7);
    drive(1'b1, 64'h64726f7773736170, 8);
    idle(LAT + 4);

    // R7: same candidate misses under the old target, hits after a load
    drive(1'b1, 64'h0000000000636261, 3);
    idle(LAT + 4);
    load_tgt(ref_md5(64'h0000000000636261, 3));
    drive(1'b1, 64'h0000000000636261, 3);
    idle(LAT + 4);

    // R9 R2 R5: random stream with bursts, bubbles and junk bytes
    secret = 64'h0000217a65627261;
    load_tgt(ref_md5(secret, 6));
    for (int i = 0; i < 3; i++) drive(1'b1, secret, 6);
    for (int i = 0; i < 700; i++) begin
      r = $urandom % 8;
      if (r == 0) drive(1'b0, secret, 6);
      else if (r == 1) drive(1'b1, {16'($urandom), secret[47:0]}, 6);
      else if (r == 2) drive(1'b1, secret, 5 + 2 * ($urandom % 2));
      else begin
        n = $urandom % 9;
        c = '0;
        for (int j = 0; j < 8; j++) c[8*j +: 8] = 8'(32 + ($urandom % 95));
        drive(1'b1, c, n);
      end
    end
    idle(LAT + 4);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule